// File: doc/BRIEF.md
# Mailbox Transaction Sequencer

This block drives one complete mailbox exchange with a firmware-serviced register file. It works from the host side and uses a byte-wide request/acknowledge register port. A caller pulses `start` with a command byte, a read/write flag and a 32-bit argument. The sequencer then performs every access of the exchange on its own. It posts a pending marker, loads the command and the argument, and rings the firmware doorbell. It then polls the status register until the completion bit shows, waiting a programmable gap between polls. On read commands it gathers the 32-bit reply. It finishes by acknowledging the alert with a write-one-to-clear.

The result is a one-cycle `done` pulse, with `err` and `dout` valid alongside it. `err` is set when the firmware never signals completion within the poll budget, or when any register access reports a bus error. In either case the exchange stops at that point.

Top module: `mbox_txn_seq`

## Requirements
- R1: After reset `bus_req`, `done` and `err` are low and `dout` is zero.
- R2: A transaction's first six accesses are writes in this order: 0x80 to address 0x3F, then `cmd` to 0x38, then `din` bytes to 0x39, 0x3A, 0x3B and 0x3C, least significant byte first. The seventh access writes 0x01 to address 0x40.
- R3: A raised `bus_req` keeps `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack` is seen. Each `bus_ack` cycle completes exactly one access.
- R4: After the doorbell, status address 0x02 is read repeatedly until a read returns bit 1 set. No more than `POLL_MAX` (default 11) status reads are made.
- R5: Between two status reads, `bus_req` stays low for at least `poll_gap`+1 cycles, so successive poll acknowledges are at least `poll_gap`+2 cycles apart.
- R6: If `POLL_MAX` status reads all return bit 1 clear, the transaction ends with `done` and `err` high. No reply reads and no clear write are made, and `dout` stays zero.
- R7: For a read transaction (`is_read`=1), addresses 0x31 to 0x34 are read after completion is seen. The first byte read lands in `dout[7:0]` and the last in `dout[31:24]`. Write transactions make no such reads and leave `dout` at zero.
- R8: The final access writes the last status value read, with bit 1 forced to one, to address 0x02. `done` then pulses with `err` low.
- R9: An access acknowledged with `bus_err` high ends the transaction at once with `done` and `err`. No further access is made.
- R10: A `start` pulse during a transaction has no effect on that transaction's accesses. `dout` is cleared when a new transaction begins.
- R11: `done` is high for exactly one cycle per transaction. `err` rises only together with `done` and holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| cmd | input | 8 | Command byte |
| is_read | input | 1 | 1: collect a 32-bit reply |
| din | input | 32 | Command argument |
| poll_gap | input | GAP_W | Idle cycles between status polls, minus one |
| dout | output | 32 | Reply data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout or bus error, valid with `done` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1: write, 0: read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |

## Verification
Read and write commands are run with completion arriving on the first poll, on the last allowed poll and never. These cases separate a correct retry budget from one that is off by one in either direction, and show whether the reply reads are skipped on writes. Bus errors are injected on the very first access and in the middle of the reply reads. This shows that the abort is immediate and that a partly assembled reply is what remains. Random commands, arguments, status bytes, reply words, poll gaps and acknowledge latencies confirm byte ordering and gap timing across many combinations. A start pulse issued mid-transaction checks that a busy sequencer ignores it.

// File: rtl/mbox_txn_seq.sv
module mbox_txn_seq #(
  parameter int POLL_MAX = 11,
  parameter int GAP_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd,
  input  logic             is_read,
  input  logic [31:0]      din,
  input  logic [GAP_W-1:0] poll_gap,
  output logic [31:0]      dout,
  output logic             done,
  output logic             err,
  output logic             bus_req,
  output logic             bus_we,
  output logic [7:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_err
);

  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

  localparam logic [3:0] ST_PEND = 4'd0;
  localparam logic [3:0] ST_CMD  = 4'd1;
  localparam logic [3:0] ST_TRIG = 4'd6;
  localparam logic [3:0] ST_POLL = 4'd7;
  localparam logic [3:0] ST_RSP0 = 4'd8;
  localparam logic [3:0] ST_CLR  = 4'd12;

  localparam logic [7:0] A_PEND = 8'h3F;
  localparam logic [7:0] A_CMD  = 8'h38;
  localparam logic [7:0] A_ARG0 = 8'h39;
  localparam logic [7:0] A_TRIG = 8'h40;
  localparam logic [7:0] A_STAT = 8'h02;
  localparam logic [7:0] A_RSP0 = 8'h31;
  localparam logic [7:0] ALERT  = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP} state_t;

  state_t           st;
  logic [3:0]       step;
  logic [PW-1:0]    polls;
  logic [GAP_W-1:0] gap_cnt;
  logic [7:0]       cmd_q, stat_q;
  logic [31:0]      din_q;
  logic             rd_q;
  logic [1:0]       arg_lane;

  assign bus_req  = (st == S_ACC);
  assign arg_lane = 2'(step - 4'd2);

  always_comb begin
    bus_we    = 1'b1;
    bus_addr  = A_STAT;
    bus_wdata = stat_q | ALERT;
    case (step)
      ST_PEND: begin bus_addr = A_PEND; bus_wdata = 8'h80; end
      ST_CMD:  begin bus_addr = A_CMD;  bus_wdata = cmd_q; end
      4'd2, 4'd3, 4'd4, 4'd5: begin
        bus_addr  = A_ARG0 + {6'd0, arg_lane};
        bus_wdata = din_q[{arg_lane, 3'b000} +: 8];
      end
      ST_TRIG: begin bus_addr = A_TRIG; bus_wdata = 8'h01; end
      ST_POLL: begin bus_we = 1'b0; bus_addr = A_STAT; bus_wdata = 8'h00; end
      4'd8, 4'd9, 4'd10, 4'd11: begin
        bus_we    = 1'b0;
        bus_addr  = A_RSP0 + {6'd0, step[1:0]};
        bus_wdata = 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= ST_PEND;
      polls   <= '0;
      gap_cnt <= '0;
      cmd_q   <= '0;
      din_q   <= '0;
      rd_q    <= 1'b0;
      stat_q  <= '0;
      dout    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_ACC;
          step  <= ST_PEND;
          polls <= '0;
          dout  <= '0;
          err   <= 1'b0;
          cmd_q <= cmd;
          din_q <= din;
          rd_q  <= is_read;
        end
        S_ACC: if (bus_ack) begin
          if (bus_err) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            case (step)
              ST_POLL: begin
                stat_q <= bus_rdata;
                if (bus_rdata[1]) begin
                  step <= rd_q ? ST_RSP0 : ST_CLR;
                end else if (polls == POLL_LAST) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                  err  <= 1'b1;
                end else begin
                  polls   <= polls + 1'b1;
                  gap_cnt <= poll_gap;
                  st      <= S_GAP;
                end
              end
              4'd8, 4'd9, 4'd10, 4'd11: begin
                dout[{step[1:0], 3'b000} +: 8] <= bus_rdata;
                step <= step + 4'd1;
              end
              ST_CLR: begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
              default: step <= step + 4'd1;
            endcase
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) st <= S_ACC;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_first_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && start |=> bus_req && bus_we && bus_addr == A_PEND && bus_wdata == 8'h80);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_clear_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == A_STAT |-> bus_wdata[1]);

  p_poll_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> polls <= POLL_LAST);

endmodule

// File: tb/sim_mbox_txn_seq.sv
module sim_mbox_txn_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_read = 1'b0;
  logic [7:0] cmd = '0;
  logic [31:0] din = '0;
  logic [15:0] poll_gap = '0;
  logic [31:0] dout;
  logic done, err, bus_req, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic bus_ack = 1'b0, bus_err = 1'b0;

  always #2 clk = ~clk;

  mbox_txn_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .is_read(is_read),
    .din(din), .poll_gap(poll_gap), .dout(dout), .done(done), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err));

  int tests = 0, fails = 0;
  int cyc = 0;
  int n_log, polls_seen, ready_at, err_at, lat;
  logic [7:0] stat_base;
  logic [31:0] rsp;
  logic [7:0] lg_addr[32], lg_wd[32];
  logic lg_we[32];
  int poll_cyc[32];

  int exp_n;
  logic [7:0] ex_addr[32], ex_wd[32];
  logic ex_we[32];
  logic exp_err;
  logic [31:0] exp_dout;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bus_ack) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
    end else if (bus_req) begin
      if (lat > 0) lat--;
      else begin
        bus_ack = 1'b1;
        bus_err = (n_log == err_at);
        bus_rdata = 8'($urandom);
        if (n_log < 32) begin
          lg_addr[n_log] = bus_addr; lg_we[n_log] = bus_we; lg_wd[n_log] = bus_wdata;
        end
        if (!bus_we && bus_addr == 8'h02) begin
          if (polls_seen < 32) poll_cyc[polls_seen] = cyc;
          polls_seen++;
          bus_rdata = (polls_seen >= ready_at) ? (stat_base | 8'h02) : (stat_base & 8'hFD);
        end else if (!bus_we && bus_addr >= 8'h31 && bus_addr <= 8'h34)
          bus_rdata = rsp[8*(bus_addr - 8'h31) +: 8];
        n_log++;
        lat = $urandom % 3;
      end
    end
  end

  function automatic void push(input logic [7:0] a, input logic w, input logic [7:0] d);
    ex_addr[exp_n] = a; ex_we[exp_n] = w; ex_wd[exp_n] = d;
    exp_n++;
  endfunction

  function automatic void build(input logic [7:0] c, input logic rd, input logic [31:0] d);
    exp_n = 0; exp_err = 1'b0; exp_dout = '0;
    push(8'h3F, 1'b1, 8'h80);
    push(8'h38, 1'b1, c);
    for (int i = 0; i < 4; i++) push(8'h39 + 8'(i), 1'b1, d[8*i +: 8]);
    push(8'h40, 1'b1, 8'h01);
    for (int i = 0; i < ((ready_at <= 11) ? ready_at : 11); i++) push(8'h02, 1'b0, 8'h00);
    if (ready_at > 11) exp_err = 1'b1;
    else begin
      if (rd) for (int i = 0; i < 4; i++) begin
        if (err_at < 0 || exp_n < err_at) exp_dout[8*i +: 8] = rsp[8*i +: 8];
        push(8'h31 + 8'(i), 1'b0, 8'h00);
      end
      push(8'h02, 1'b1, stat_base | 8'h02);
    end
    if (err_at >= 0 && err_at < exp_n) begin
      exp_n = err_at + 1;
      exp_err = 1'b1;
    end
  endfunction

  task automatic run(input logic [7:0] c, input logic rd, input logic [31:0] d,
                     input int rdy, input int ea, input logic [15:0] gap, input bit poke);
    int guard;
    ready_at = rdy; err_at = ea; stat_base = 8'($urandom); rsp = $urandom;
    n_log = 0; polls_seen = 0;
    build(c, rd, d);
    @(negedge clk);
    cmd = c; is_read = rd; din = d; poll_gap = gap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmd = ~c; din = ~d; is_read = ~rd;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R11", "done seen", 32'(guard), 32'd0);
    chk(n_log == exp_n, (ready_at > 11) ? "R6" : (err_at >= 0 ? "R9" : "R4"), "access count",
        32'(n_log), 32'(exp_n));
    for (int i = 0; i < exp_n && i < n_log; i++) begin
      chk(lg_addr[i] == ex_addr[i] && lg_we[i] == ex_we[i],
          i < 7 ? (poke ? "R10" : "R2") : (ex_addr[i] == 8'h02 ? "R4" : "R7"), "access addr/we",
          {23'd0, lg_we[i], lg_addr[i]}, {23'd0, ex_we[i], ex_addr[i]});
      if (ex_we[i])
        chk(lg_wd[i] == ex_wd[i], ex_addr[i] == 8'h02 ? "R8" : "R2", "write data",
            32'(lg_wd[i]), 32'(ex_wd[i]));
    end
    for (int j = 1; j < polls_seen && j < 32; j++)
      chk(poll_cyc[j] - poll_cyc[j-1] >= int'(gap) + 2, "R5", "poll spacing",
          32'(poll_cyc[j] - poll_cyc[j-1]), 32'(int'(gap) + 2));
    chk(err == exp_err, exp_err ? ((ready_at > 11) ? "R6" : "R9") : "R8", "err", 32'(err), 32'(exp_err));
    chk(dout == exp_dout, rd ? "R7" : "R10", "dout", dout, exp_dout);
    @(negedge clk);
    chk(!done, "R11", "done width", 32'(done), 32'd0);
    chk(err == exp_err, "R11", "err held", 32'(err), 32'(exp_err));
    chk(!bus_req, "R9", "quiet after end", 32'(bus_req), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    lat = 0; err_at = -1; ready_at = 1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !done && !err && dout == 0, "R1", "reset state",
        {29'd0, bus_req, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && dout == 0, "R1", "idle after reset", {31'd0, bus_req}, 32'd0);
    run(8'h01, 1'b1, 32'h11223344, 1, -1, 16'd0, 1'b0);
    run(8'h02, 1'b0, 32'hA5B6C7D8, 11, -1, 16'd5, 1'b0);
    run(8'h03, 1'b1, 32'h0, 12, -1, 16'd2, 1'b0);
    run(8'h04, 1'b1, 32'hFFFFFFFF, 3, 0, 16'd1, 1'b0);
    run(8'h05, 1'b1, 32'h01020304, 2, 10, 16'd1, 1'b0);
    run(8'h06, 1'b1, 32'hCAFEF00D, 4, -1, 16'd40, 1'b1);
    run(8'h07, 1'b0, 32'h12345678, 2, -1, 16'd3, 1'b0);
    for (int k = 0; k < 24; k++)
      run(8'($urandom), 1'($urandom), $urandom, 1 + ($urandom % 13),
          ($urandom % 5 == 0) ? int'($urandom % 24) : -1, 16'($urandom % 30), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule